// File: doc/BRIEF.md
# Divider Chain with Test Selector

This block is the digital divider path of a clock synthesizer. The analog phase detector and oscillator sit outside it. The block sees three clock sources as single-cycle tick strobes on a fast core clock: the oscillator, the crystal and a serial clock. It derives three things from them:

- a phase-detector reference, equal to the crystal ticks divided by eight;
- a feedback pulse, produced by a loop counter programmed with a 9-bit modulus;
- the main output, produced by a divider of 2, 4, 8 or 16 with an even duty cycle.

A 3-bit selector routes one internal node onto a single test pin. One code of that selector puts the block into a bypass mode. In bypass the serial clock, not the oscillator, drives both the loop counter and the output divider. This allows board-level stepping without the loop.

A change to a divider ratio is taken up only at the start of that divider's next period. When the source changes, both dividers are cleared, so they restart in a known phase.

Top module: `divchain_top`

## Requirements
- R1: The reference node has a period of 8 crystal ticks, high for 4 and low for 4.
- R2: The feedback output is high for exactly one source tick once every M source ticks, where M is the unsigned value of `m_div[8:0]`.
- R3: A modulus of 0 or 1 is treated as 2.
- R4: `fout` has a period of 2, 4, 8 or 16 source ticks for `n_sel` = 00, 01, 10 or 11, and is high for half of each period.
- R5: New `n_sel` or `m_div` values are sampled only at the start of a divider period. Every completed period therefore uses either the old ratio or the new one, and each `fout` period keeps a 50% duty cycle.
- R6: `test_out` shows, for `t_sel` 000 through 111: `sr_last`; constant 1; the reference node; the feedback; `fout`; constant 0; the feedback (bypass); and `fout` divided by 4 with 50% duty.
- R7: With `t_sel` = 110, both dividers count `sclk_tick` and ignore `vco_tick`.
- R8: With `t_sel` other than 110, `sclk_tick` has no effect on `fout` or the feedback.
- R9: A change into or out of bypass clears both dividers. After the clear, `fout` and the feedback are low, and the first `fout` rise comes after half a period of new-source ticks.
- R10: During reset, `fout` and `fb_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all tick strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One-cycle strobe per oscillator edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal edge |
| sclk_tick | input | 1 | One-cycle strobe per serial clock edge |
| m_div | input | 9 | Loop counter modulus |
| n_sel | input | 2 | Output divider select |
| t_sel | input | 3 | Test node select; 110 selects bypass |
| sr_last | input | 1 | Last bit of the serial shift register |
| fout | output | 1 | Divided output |
| test_out | output | 1 | Selected test node |
| fb_out | output | 1 | Loop feedback pulse |

## Verification
The assertions check, on every cycle, the properties that hold locally:

- The reference, `fout` and the feedback change only on a cycle that follows a tick of their own source, or a clear.
- The unused source has no effect in either mode.
- The constant test codes hold their levels.
- A clear always leaves both outputs low.

Some behaviours need tick counts over many periods, and only the bench's scenarios can show them. These are the exact period and duty lengths for random moduli and divider codes, the modulus floor, the old-or-new ratio rule across a mid-run change, and the half-period delay to the first rise after a source switch.

// File: rtl/divchain_pkg.sv
package divchain_pkg;

    typedef enum logic [2:0] {
        TS_LAST  = 3'b000,
        TS_HIGH  = 3'b001,
        TS_REF   = 3'b010,
        TS_FB    = 3'b011,
        TS_FOUT  = 3'b100,
        TS_LOW   = 3'b101,
        TS_BYP   = 3'b110,
        TS_FOUT4 = 3'b111
    } tsel_e;

endpackage

// File: rtl/dc_ref_prescaler.sv
module dc_ref_prescaler #(
    parameter int REF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic ref_clk
);
    localparam int CW = $clog2(REF_DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_clk = st_q.cnt[CW-1];
endmodule

// File: rtl/dc_loop_counter.sv
module dc_loop_counter #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           tick,
    input  logic [M_W-1:0] m_in,
    output logic           pulse
);
    localparam logic [M_W-1:0] M_MIN = M_W'(2);

    typedef struct packed {
        logic [M_W-1:0] cnt;
        logic [M_W-1:0] m_act;
        logic           pulse;
    } state_t;

    state_t st_d, st_q;
    logic [M_W-1:0] m_eff;
    logic [M_W-1:0] base;

    always_comb begin
        m_eff = (m_in < M_MIN) ? M_MIN : m_in;
        base  = (st_q.cnt == '0) ? m_eff : st_q.m_act;
        st_d  = st_q;
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.m_act = m_eff;
            end
            if (st_q.cnt == base - 1'b1) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.pulse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/dc_out_divider.sv
module dc_out_divider #(
    parameter int N_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           tick,
    input  logic [N_W-1:0] n_in,
    output logic           fout,
    output logic           fout_q4
);
    localparam int MAX_HALF = 1 << ((1 << N_W) - 1);
    localparam int HW       = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic [HW-1:0] half_act;
        logic          fout;
        logic [1:0]    rises;
    } state_t;

    state_t st_d, st_q;
    logic          at_start;
    logic [HW-1:0] half_new;
    logic [HW-1:0] half_use;

    always_comb begin
        at_start = (st_q.hcnt == '0) && !st_q.fout;
        half_new = HW'(1) << n_in;
        half_use = at_start ? half_new : st_q.half_act;
        st_d     = st_q;
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            if (at_start) begin
                st_d.half_act = half_new;
            end
            if (st_q.hcnt == half_use - 1'b1) begin
                st_d.hcnt = '0;
                st_d.fout = !st_q.fout;
                if (!st_q.fout) begin
                    st_d.rises = st_q.rises + 1'b1;
                end
            end else begin
                st_d.hcnt = st_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fout    = st_q.fout;
    assign fout_q4 = st_q.rises[1];
endmodule

// File: rtl/divchain_top.sv
module divchain_top #(
    parameter int M_W     = 9,
    parameter int N_W     = 2,
    parameter int T_W     = 3,
    parameter int REF_DIV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           xtal_tick,
    input  logic           sclk_tick,
    input  logic [M_W-1:0] m_div,
    input  logic [N_W-1:0] n_sel,
    input  logic [T_W-1:0] t_sel,
    input  logic           sr_last,
    output logic           fout,
    output logic           test_out,
    output logic           fb_out
);
    import divchain_pkg::*;

    typedef struct packed {
        logic byp;
        logic clr;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  byp_req;
    logic  src_tick;
    logic  ref_clk;
    logic  fout_q4;
    tsel_e tsel;

    always_comb begin
        tsel      = tsel_e'(t_sel);
        byp_req   = (tsel == TS_BYP);
        ctl_d.byp = byp_req;
        ctl_d.clr = (byp_req != ctl_q.byp);
        src_tick  = ctl_q.byp ? sclk_tick : vco_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dc_ref_prescaler #(.REF_DIV(REF_DIV)) i_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (xtal_tick),
        .ref_clk(ref_clk)
    );

    dc_loop_counter #(.M_W(M_W)) i_loop (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctl_q.clr),
        .tick (src_tick),
        .m_in (m_div),
        .pulse(fb_out)
    );

    dc_out_divider #(.N_W(N_W)) i_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctl_q.clr),
        .tick   (src_tick),
        .n_in   (n_sel),
        .fout   (fout),
        .fout_q4(fout_q4)
    );

    always_comb begin
        case (tsel)
            TS_LAST:  test_out = sr_last;
            TS_HIGH:  test_out = 1'b1;
            TS_REF:   test_out = ref_clk;
            TS_FB:    test_out = fb_out;
            TS_FOUT:  test_out = fout;
            TS_LOW:   test_out = 1'b0;
            TS_BYP:   test_out = fb_out;
            default:  test_out = fout_q4;
        endcase
    end
endmodule

// File: rtl/divchain_checker.sv
module divchain_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vco_tick,
    input logic       xtal_tick,
    input logic       sclk_tick,
    input logic [2:0] t_sel,
    input logic       fout,
    input logic       fb_out,
    input logic       test_out,
    input logic       ref_clk,
    input logic       byp,
    input logic       clr
);
    assert_ref_on_xtal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_clk) |-> $past(xtal_tick));

    assert_fb_on_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_out) |-> $past(clr || (byp ? sclk_tick : vco_tick)));

    assert_fout_on_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fout) |-> $past(clr || (byp ? sclk_tick : vco_tick)));

    assert_test_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sel == 3'b001) |-> test_out);

    assert_test_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sel == 3'b101) |-> !test_out);

    assert_vco_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byp && !clr && vco_tick && !sclk_tick) |=> ($stable(fout) && $stable(fb_out)));

    assert_sclk_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !clr && sclk_tick && !vco_tick) |=> ($stable(fout) && $stable(fb_out)));

    assert_clear_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!fout && !fb_out));
endmodule

bind divchain_top divchain_checker i_divchain_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .vco_tick (vco_tick),
    .xtal_tick(xtal_tick),
    .sclk_tick(sclk_tick),
    .t_sel    (t_sel),
    .fout     (fout),
    .fb_out   (fb_out),
    .test_out (test_out),
    .ref_clk  (ref_clk),
    .byp      (ctl_q.byp),
    .clr      (ctl_q.clr)
);

// File: tb/test_divchain_top.sv
module test_divchain_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_tick = 1'b0, xtal_tick = 1'b0, sclk_tick = 1'b0;
    logic [8:0] m_div = 9'd5;
    logic [1:0] n_sel = 2'd0;
    logic [2:0] t_sel = 3'd0;
    logic       sr_last = 1'b0;
    logic       fout, test_out, fb_out;

    int n_chk = 0, n_err = 0;
    bit lv = 0, lx = 0, ls = 0;
    bit mon_on = 0, prev = 0, seen_rise = 0;
    int mon_sel = 0, mon_src = 0, exp_per = 0, exp_alt = 0, hmode = 0;
    int tfall = 0, trise = 0, skip = 0, measured = 0;
    string mon_tag = "";

    always #4 clk = !clk;

    divchain_top i_divchain_top (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
        .sclk_tick(sclk_tick), .m_div(m_div), .n_sel(n_sel), .t_sel(t_sel),
        .sr_last(sr_last), .fout(fout), .test_out(test_out), .fb_out(fb_out)
    );

    function automatic int ratio(input logic [1:0] n);
        return 2 << n;
    endfunction

    function automatic int meff(input logic [8:0] m);
        return (m < 2) ? 2 : int'(m);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit cur_sig();
        case (mon_sel)
            0: return fout;
            1: return fb_out;
            default: return test_out;
        endcase
    endfunction

    task automatic sample();
        bit sg, tk;
        sg = cur_sig();
        tk = (mon_src == 0) ? lv : (mon_src == 1) ? lx : ls;
        if (mon_on) begin
            if (tk) begin tfall++; trise++; end
            if (!prev && sg) begin trise = 0; seen_rise = 1; end
            if (prev && !sg) begin
                if (skip > 0) skip--;
                else begin
                    measured++;
                    check(tfall == exp_per || tfall == exp_alt, {mon_tag, " period"}, tfall, exp_per);
                    if (seen_rise) begin
                        if (hmode == 1) check(trise == 1, {mon_tag, " high"}, trise, 1);
                        else check(trise * 2 == tfall, {mon_tag, " high"}, trise, tfall / 2);
                    end
                end
                tfall = 0;
            end
            prev = sg;
        end
    endtask

    task automatic step(input bit v, input bit x, input bit s);
        @(negedge clk);
        sample();
        vco_tick = v; xtal_tick = x; sclk_tick = s;
        lv = v; lx = x; ls = s;
    endtask

    task automatic rstep();
        step(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    endtask

    task automatic run_mon(input int sel, input int src, input int per, input int alt,
                           input int hm, input int n, input int sk, input bit fresh,
                           input string tag);
        mon_sel = sel; mon_src = src; exp_per = per; exp_alt = alt; hmode = hm;
        skip = sk; measured = 0; mon_tag = tag;
        if (fresh) begin
            prev = cur_sig(); tfall = 0; trise = 0; seen_rise = 0;
        end
        mon_on = 1;
        while (measured < n) rstep();
        mon_on = 0;
    endtask

    initial begin
        int r, cnt, changes;
        bit f0, b0;
        void'($urandom(32'd2718));
        repeat (3) step(0, 0, 0);
        check(fout == 1'b0, "R10 fout in reset", int'(fout), 0);
        check(fb_out == 1'b0, "R10 fb in reset", int'(fb_out), 0);
        rst_n = 1'b1;
        step(0, 0, 0);

        // R2 and R4: random moduli and divider codes
        for (int i = 0; i < 5; i++) begin
            m_div = 9'(2 + $urandom % 29);
            n_sel = 2'($urandom % 4);
            run_mon(1, 0, meff(m_div), meff(m_div), 1, 3, 2, 1, "R2 fb");
            run_mon(0, 0, ratio(n_sel), ratio(n_sel), 0, 3, 2, 1, "R4 fout");
        end
        for (int n = 0; n < 4; n++) begin
            n_sel = 2'(n);
            run_mon(0, 0, ratio(n_sel), ratio(n_sel), 0, 3, 2, 1, "R4 fout code");
        end

        // R3: modulus floor
        m_div = 9'd0;
        run_mon(1, 0, 2, 2, 1, 3, 2, 1, "R3 m=0");
        m_div = 9'd1;
        run_mon(1, 0, 2, 2, 1, 3, 2, 1, "R3 m=1");

        // R1 via test pin, code 010
        t_sel = 3'b010;
        run_mon(2, 1, 8, 8, 0, 4, 2, 1, "R1 ref");

        // R6: test selector codes
        m_div = 9'd7; n_sel = 2'd1;
        t_sel = 3'b011;
        run_mon(2, 0, 7, 7, 1, 3, 2, 1, "R6 test fb");
        t_sel = 3'b111;
        run_mon(2, 0, 16, 16, 0, 3, 2, 1, "R6 test fout/4");
        t_sel = 3'b000;
        for (int i = 0; i < 12; i++) begin
            sr_last = 1'($urandom % 2);
            step(0, 0, 0);
            step(0, 0, 0);
            check(test_out == sr_last, "R6 test sr_last", int'(test_out), int'(sr_last));
        end
        t_sel = 3'b001; step(0, 0, 0); step(0, 0, 0);
        check(test_out == 1'b1, "R6 test high", int'(test_out), 1);
        t_sel = 3'b101; step(0, 0, 0); step(0, 0, 0);
        check(test_out == 1'b0, "R6 test low", int'(test_out), 0);
        t_sel = 3'b100;
        for (int i = 0; i < 40; i++) begin
            rstep();
            check(test_out == fout, "R6 test fout", int'(test_out), int'(fout));
        end
        t_sel = 3'b000;

        // R5: ratio change mid-run
        n_sel = 2'd3;
        run_mon(0, 0, 16, 16, 0, 2, 2, 1, "R5 fout old");
        n_sel = 2'd0;
        run_mon(0, 0, 2, 16, 0, 4, 0, 0, "R5 fout change");
        m_div = 9'd20;
        run_mon(1, 0, 20, 20, 1, 2, 2, 1, "R5 fb old");
        m_div = 9'd3;
        run_mon(1, 0, 3, 20, 1, 4, 0, 0, "R5 fb change");

        // R8: serial ticks ignored in normal mode
        n_sel = 2'd1;
        repeat (30) rstep();
        step(0, 0, 0);
        step(0, 0, 0);
        f0 = fout; b0 = fb_out; changes = 0;
        for (int i = 0; i < 150; i++) begin
            step(0, 0, 1);
            if (fout != f0 || fb_out != b0) changes++;
        end
        check(changes == 0, "R8 sclk ignored", changes, 0);

        // R9: switch into bypass clears dividers
        n_sel = 2'd2; m_div = 9'd6;
        cnt = 0;
        while (!fout && cnt < 400) begin rstep(); cnt++; end
        step(0, 0, 0);
        t_sel = 3'b110;
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        check(fout == 1'b0, "R9 fout cleared", int'(fout), 0);
        check(fb_out == 1'b0, "R9 fb cleared", int'(fb_out), 0);
        cnt = 0;
        do begin
            step(0, 0, 1);
            step(0, 0, 0);
            cnt++;
        end while (!fout && cnt < 40);
        check(cnt == ratio(n_sel) / 2, "R9 first rise", cnt, ratio(n_sel) / 2);

        // R7: bypass counts serial ticks, vco ignored
        run_mon(0, 2, 8, 8, 0, 3, 2, 1, "R7 bypass fout");
        run_mon(2, 2, 6, 6, 1, 3, 2, 1, "R7 bypass test fb");
        f0 = fout; b0 = fb_out; changes = 0;
        step(0, 0, 0);
        f0 = fout; b0 = fb_out;
        for (int i = 0; i < 100; i++) begin
            step(1, 0, 0);
            if (fout != f0 || fb_out != b0) changes++;
        end
        check(changes == 0, "R7 vco ignored", changes, 0);

        // leave bypass: clear again, normal source
        t_sel = 3'b000;
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        check(fout == 1'b0, "R9 leave clear", int'(fout), 0);
        r = ratio(n_sel);
        run_mon(0, 0, r, r, 0, 3, 2, 1, "R9 back to vco");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(150000 * 8);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule